// File: doc/BRIEF.md
# Motion Delta Accumulator

This block sums the signed X and Y displacement steps reported once per frame by the motion-estimation logic. It holds the totals until a host reads them over the serial register port. Each axis total is shown as an 8-bit two's-complement register value. A sticky motion flag is shown in bit 7 of a status register value. The serial front end passes register read and write strobes with a 7-bit address. The block reacts to those strobes only at the addresses it owns.

A one-bit resolution control picks the scaling. In full-count mode every raw step is added as it comes. In half-count mode each axis adds half of each step and keeps a one-bit remainder, so odd steps are carried over and not lost. Totals clip at the ends of the 8-bit range and do not wrap. A read of the X total also copies the live Y total into a holding register. The Y read that follows returns that copy, so both halves of a report come from the same moment.

Top module: `mda_top`

## Requirements
- R1: After reset the status value, both delta values and the resolution select are all zero, so the block starts in half-count mode.
- R2: With the resolution select at 1, written as bit 0 of a write to address 0x0d, each strobe adds the raw signed steps to the totals.
- R3: With the resolution select at 0, each axis adds floor((step + remainder)/2) and keeps the low bit of (step + remainder) as its new remainder. So two +1 steps add +1, and a -3 step from remainder 0 adds -2.
- R4: Each total clips at +127 (0x7F) and -128 (0x80) and never wraps.
- R5: A read of address 0x03 clears the X total. Steps arriving later build a new total.
- R6: A read of address 0x03 copies the live Y total into a holding register and clears the live Y total. While the copy is held, the Y output shows the copy, and later Y steps go into the live total. A read of address 0x04 drops the copy, and the Y output then shows the live total.
- R7: A read of address 0x04 while no copy is held clears the live Y total.
- R8: Status bit 7 is set by any strobe whose scaled step is nonzero on either axis, and it stays set. A read of 0x03 or a write to 0x02 clears it. Status bits 6..0 are always 0.
- R9: Any write to address 0x02 clears the flag, both totals, the held copy and both remainders. The written byte is not stored.
- R10: A step strobe in the same cycle as a clearing read or write leaves just that step in the total. The flag then ends up set exactly when that step is nonzero.
- R11: Writes to addresses other than 0x02 and 0x0d, and reads of addresses other than 0x03 and 0x04, change nothing. A write to 0x0d uses only bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_vld_i | input | 1 | Per-frame step strobe |
| step_x_i | input | 8 | Signed raw X step |
| step_y_i | input | 8 | Signed raw Y step |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Register write data |
| motion_o | output | 8 | Status register value (flag in bit 7) |
| delta_x_o | output | 8 | X total register value |
| delta_y_o | output | 8 | Y register value (held copy or live total) |

## Verification
The hardest case to reach is the window between an X read and the Y read that follows, when new Y steps keep arriving. The Y output must keep showing the copy while the live total grows unseen. The bench places step strobes between the two reads, then checks both the copy and the total that shows up after the Y read. It also puts step strobes in the same cycle as clearing reads and writes. That exercises the rule that a step arriving with a clear replaces the old total, including the case where the step is zero.

// File: rtl/mda_pkg.sv
package mda_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] A_STATUS = 7'h02;
  localparam logic [ADDR_W-1:0] A_DX     = 7'h03;
  localparam logic [ADDR_W-1:0] A_DY     = 7'h04;
  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h0d;
  localparam int FLAG_BIT = 7;
endpackage

// File: rtl/mda_axis.sv
module mda_axis #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 half_i,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] step_i,
  input  logic                 clr_i,
  input  logic                 rem_clr_i,
  output logic signed [CW-1:0] acc_o,
  output logic                 step_nz_o
);
  localparam int SW = DW + 1;
  localparam int AW = ((CW > SW) ? CW : SW) + 1;
  localparam logic signed [AW-1:0] MAXV = AW'(2**(CW-1) - 1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [CW-1:0] acc_q, acc_d;
  logic                 rem_q, rem_d, rem_use;
  logic signed [SW-1:0] full_v, scaled_v;
  logic signed [AW-1:0] base_v, sum_v;

  always_comb begin
    rem_use  = rem_clr_i ? 1'b0 : rem_q;
    full_v   = SW'(step_i) + SW'({1'b0, rem_use});
    scaled_v = half_i ? (full_v >>> 1) : SW'(step_i);
    base_v   = clr_i ? '0 : AW'(acc_q);
    sum_v    = base_v + AW'(scaled_v);
    if (!valid_i)           acc_d = CW'(base_v);
    else if (sum_v > MAXV)  acc_d = CW'(MAXV);
    else if (sum_v < MINV)  acc_d = CW'(MINV);
    else                    acc_d = CW'(sum_v);
    if (valid_i)            rem_d = half_i ? full_v[0] : 1'b0;
    else                    rem_d = rem_use;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rem_q <= rem_d;
    end
  end

  assign acc_o     = acc_q;
  assign step_nz_o = valid_i && (scaled_v != '0);

  // R4: a non-negative total plus a non-negative step stays non-negative
  p_no_wrap_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && !acc_q[CW-1] && !scaled_v[SW-1]) |=> !acc_q[CW-1]);
  p_no_wrap_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && acc_q[CW-1] && scaled_v[SW-1]) |=> acc_q[CW-1]);
  // R5 / R7: clearing without a new step leaves zero
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> (acc_q == '0));
endmodule

// File: rtl/mda_ctrl.sv
module mda_ctrl
  import mda_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [RW-1:0]     wdata_i,
  output logic              full_res_o
);
  logic res_q;
  logic unused_wbits;
  assign unused_wbits = ^wdata_i[RW-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      res_q <= 1'b0;
    else if (wr_i && addr_i == A_CTRL) res_q <= wdata_i[0];
  end

  assign full_res_o = res_q;

  // R11: the select moves only on a write to its own address
  p_ctrl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_CTRL) |=> $stable(res_q));
endmodule

// File: rtl/mda_top.sv
module mda_top
  import mda_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_vld_i,
  input  logic [DW-1:0]     step_x_i,
  input  logic [DW-1:0]     step_y_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     motion_o,
  output logic [CW-1:0]     delta_x_o,
  output logic [CW-1:0]     delta_y_o
);
  localparam int NAX = 2;

  logic full_res;
  logic rd_x, rd_y, wclr;
  logic [NAX-1:0] clr, nz;
  logic signed [DW-1:0] step_in [NAX];
  logic signed [CW-1:0] acc [NAX];
  logic flag_q, hold_v_q;
  logic [CW-1:0] hold_q;

  assign rd_x = rd_i && addr_i == A_DX;
  assign rd_y = rd_i && addr_i == A_DY;
  assign wclr = wr_i && addr_i == A_STATUS;

  assign clr[0] = wclr || rd_x;
  assign clr[1] = wclr || rd_x || (rd_y && !hold_v_q);
  assign step_in[0] = step_x_i;
  assign step_in[1] = step_y_i;

  mda_ctrl #(.RW(CW)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .full_res_o(full_res)
  );

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    mda_axis #(.DW(DW), .CW(CW)) u_axis (
      .clk_i, .rst_ni,
      .half_i(!full_res),
      .valid_i(step_vld_i),
      .step_i(step_in[g]),
      .clr_i(clr[g]),
      .rem_clr_i(wclr),
      .acc_o(acc[g]),
      .step_nz_o(nz[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      flag_q <= ((wclr || rd_x) ? 1'b0 : flag_q) | (|nz);
      if (wclr) begin
        hold_v_q <= 1'b0;
      end else if (rd_x) begin
        hold_v_q <= 1'b1;
        hold_q   <= acc[1];
      end else if (rd_y) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  always_comb begin
    motion_o           = '0;
    motion_o[FLAG_BIT] = flag_q;
  end
  assign delta_x_o = acc[0];
  assign delta_y_o = hold_v_q ? hold_q : acc[1];

  // R8: a nonzero scaled step always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_vld_i && (|nz)) |=> motion_o[FLAG_BIT]);
  // R6: an X read presents the pre-read live Y total on the Y output
  p_snapshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_x && !wclr) |=> (delta_y_o == $past(acc[1])));
  // R9: a clearing write with no step empties everything
  p_wclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclr && !step_vld_i) |=> (motion_o == '0 && delta_x_o == '0 && delta_y_o == '0));
endmodule

// File: tb/sim_mda_top.sv
module sim_mda_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] sx = '0, sy = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] mot, dx, dy;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mda_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_vld_i(vld), .step_x_i(sx), .step_y_i(sy),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .motion_o(mot), .delta_x_o(dx), .delta_y_o(dy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [7:0] m, input logic [7:0] x, input logic [7:0] y);
    chk({req, " motion"}, mot, m);
    chk({req, " dx"}, dx, x);
    chk({req, " dy"}, dy, y);
  endtask

  // one-cycle operation; any combination of strobes
  task automatic op(input bit v, input logic [7:0] x, input logic [7:0] y,
                    input bit r, input bit w, input logic [6:0] a, input logic [7:0] d);
    vld = v; sx = x; sy = y; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    vld = 0; rd = 0; wr = 0; sx = '0; sy = '0; addr = '0; wdata = '0;
  endtask

  task automatic step(input logic [7:0] x, input logic [7:0] y); op(1, x, y, 0, 0, 7'h00, 8'h00); endtask
  task automatic rdr(input logic [6:0] a); op(0, 0, 0, 1, 0, a, 8'h00); endtask
  task automatic wrr(input logic [6:0] a, input logic [7:0] d); op(0, 0, 0, 0, 1, a, d); endtask

  task automatic t_reset_half();
    chk3("R1 reset", 8'h00, 8'h00, 8'h00);
    step(8'h01, 8'h01);
    chk3("R3 half first odd", 8'h00, 8'h00, 8'h00);
    step(8'h01, 8'h01);
    chk3("R3 half carry R8", 8'h80, 8'h01, 8'h01);
    wrr(7'h02, 8'hff);
    chk3("R9 write clear", 8'h00, 8'h00, 8'h00);
    step(8'h01, 8'h00);
    wrr(7'h02, 8'h00);
    step(8'h01, 8'h00);
    chk("R9 remainder cleared", dx, 8'h00);
  endtask

  task automatic t_half_neg();
    wrr(7'h02, 8'h00);
    step(8'hff, 8'hfd);
    chk3("R3 half negative", 8'h80, 8'hff, 8'hfe);
    step(8'h01, 8'h03);
    chk3("R3 half back to zero R8 sticky", 8'h80, 8'h00, 8'h00);
  endtask

  task automatic t_full();
    wrr(7'h0d, 8'h01);
    wrr(7'h02, 8'h00);
    step(8'd5, 8'hfd);
    step(8'hfe, 8'hfc);
    chk3("R2 full sum", 8'h80, 8'h03, 8'hf9);
  endtask

  task automatic t_sat();
    wrr(7'h02, 8'h00);
    step(8'd100, 8'h9c);
    step(8'd100, 8'h9c);
    chk("R4 high clip", dx, 8'h7f);
    chk("R4 low clip", dy, 8'h80);
    step(8'hff, 8'h01);
    chk("R4 leave high", dx, 8'h7e);
    chk("R4 leave low", dy, 8'h81);
  endtask

  task automatic t_read_snap();
    wrr(7'h02, 8'h00);
    step(8'd10, 8'd20);
    rdr(7'h03);
    chk3("R5 R6 R8 after X read", 8'h00, 8'h00, 8'd20);
    step(8'd3, 8'd4);
    chk3("R6 copy held", 8'h80, 8'd3, 8'd20);
    rdr(7'h04);
    chk3("R6 live after Y read", 8'h80, 8'd3, 8'd4);
    rdr(7'h04);
    chk("R7 Y read clears live", dy, 8'h00);
    chk("R7 X untouched", dx, 8'd3);
  endtask

  task automatic t_same_cycle();
    wrr(7'h02, 8'h00);
    step(8'd7, 8'd7);
    op(1, 8'd2, 8'hff, 1, 0, 7'h03, 8'h00);
    chk3("R10 read X with step", 8'h80, 8'd2, 8'd7);
    op(1, 8'd0, 8'd5, 1, 0, 7'h04, 8'h00);
    chk("R10 R6 Y live kept", dy, 8'd4);
    op(1, 8'hfd, 8'h00, 0, 1, 7'h02, 8'h00);
    chk3("R10 write with step", 8'h80, 8'hfd, 8'h00);
    op(1, 8'h00, 8'h00, 0, 1, 7'h02, 8'h00);
    chk3("R10 write with zero step", 8'h00, 8'h00, 8'h00);
    step(8'h00, 8'd9);
    op(1, 8'h00, 8'd2, 1, 0, 7'h04, 8'h00);
    chk("R10 R7 read Y with step", dy, 8'd2);
  endtask

  task automatic t_ignore();
    wrr(7'h0d, 8'h01);
    wrr(7'h02, 8'h00);
    step(8'd4, 8'd6);
    wrr(7'h05, 8'hff);
    wrr(7'h03, 8'h55);
    wrr(7'h04, 8'h55);
    rdr(7'h02);
    rdr(7'h10);
    chk3("R11 stray accesses", 8'h80, 8'd4, 8'd6);
    wrr(7'h0d, 8'hfe);
    step(8'd2, 8'd2);
    chk("R11 ctrl bit0 only x", dx, 8'd5);
    chk("R11 ctrl bit0 only y", dy, 8'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_half();
    t_half_neg();
    t_full();
    t_sat();
    t_read_snap();
    t_same_cycle();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule